// File: doc/BRIEF.md
# Serial Port Interrupt Request Controller

This block turns the status of a synchronous serial port into interrupt request lines for an interrupt controller. It keeps the data-ready flags for both directions: transmit-empty, set when the shifter takes a word, and receive-full, set when a word arrives. It also keeps sticky underrun and overrun flags. A software-visible control word holds six enable bits, and the block combines each flag with its enable into a level request. For each direction only one request is shown at a time. An exception request replaces the ordinary data request while its condition holds.

In time-slotted network operation, the block also produces single-cycle requests around the final slot of every frame. These are raised from frame-timing strobes that the port supplies. They do not depend on any slot mask. When the frame-rate divider field is zero, the port is in on-demand mode and both of these requests are held off. Accesses to the data registers clear the flags. A write to any enabled transmit channel, or to the dummy slot register, empties the transmit side. A read of the receive register drains the receive side.

Top module: `sp_irq_ctrl`

## Requirements
- R1: A cycle with `cfg_wr` high loads `cfg_wdata` into the enables. Bit 0 is transmit data, bit 1 receive data, bit 2 transmit last slot, bit 3 receive last slot, bit 4 transmit exception and bit 5 receive exception. After a hardware reset all enables and flags are zero.
- R2: `irq_tx` is high exactly while the transmit data enable and `tx_empty` are both set, and no transmit exception request is shown.
- R3: `tx_empty` clears in the cycle after a write to a transmit channel whose bit in `tx_chan_en` is set, or after a dummy slot write. A write to a channel that is not enabled leaves it set.
- R4: `irq_rx` is high exactly while the receive data enable and `rx_full` are both set, and no receive exception request is shown. A receive data read clears `rx_full`.
- R5: While `tx_underrun` and the transmit exception enable are both set, `irq_tx_exc` is high and `irq_tx` is low.
- R6: While `rx_overrun` and the receive exception enable are both set, `irq_rx_exc` is high and `irq_rx` is low.
- R7: The underrun and overrun flags are sticky. A data access clears one only if a status read came in an earlier cycle while the flag was already set. Otherwise the access leaves the flag set.
- R8: In network mode (`frame_div` nonzero) with the transmit last-slot enable set, `irq_tx_last` pulses for exactly one cycle, the cycle after `last_slot_start`.
- R9: In network mode with the receive last-slot enable set, `irq_rx_last` pulses for exactly one cycle, the cycle after `last_slot_end`.
- R10: When `frame_div` is zero (on-demand mode), neither last-slot request is raised.
- R11: A software reset pulse clears all six enables, and takes priority over a control write in the same cycle. It leaves the status flags as they are. A hardware reset clears the enables and the flags.
- R12: When a flag's set event and its clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Software reset command pulse |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 6 | Enable bits to load |
| frame_div | input | DIV_W (5) | Frame-rate divider field; zero selects on-demand mode |
| tx_wr | input | N_TX (2) | Per-channel transmit data register write strobes |
| tx_chan_en | input | N_TX (2) | Transmit channel enables |
| tx_dummy_wr | input | 1 | Write to the time-slot dummy register |
| tx_empty_set | input | 1 | Shifter has taken a transmit word |
| tx_underrun_evt | input | 1 | Transmit underrun event |
| rx_full_set | input | 1 | Shifter has delivered a receive word |
| rx_read | input | 1 | Receive data register read |
| rx_overrun_evt | input | 1 | Receive overrun event |
| stat_read | input | 1 | Status register read |
| last_slot_start | input | 1 | Pulse at the start of the final slot of a frame |
| last_slot_end | input | 1 | Pulse after the final slot of a frame ends |
| irq_tx | output | 1 | Transmit data request (level) |
| irq_tx_exc | output | 1 | Transmit data with exception request (level) |
| irq_rx | output | 1 | Receive data request (level) |
| irq_rx_exc | output | 1 | Receive data with exception request (level) |
| irq_tx_last | output | 1 | Transmit last-slot request (one-cycle pulse) |
| irq_rx_last | output | 1 | Receive last-slot request (one-cycle pulse) |
| tx_empty | output | 1 | Transmit-empty flag |
| rx_full | output | 1 | Receive-full flag |
| tx_underrun | output | 1 | Sticky underrun flag |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The properties assume that the frame strobes are single-cycle events supplied by the port, and that `frame_div` stays steady across a strobe and the cycle after it. The stimulus respects this: it changes the divider only in idle cycles, and it raises each strobe for one cycle with an idle cycle after it. The sticky-flag property assumes that only the listed data accesses count as clearing events. The bench drives every access as a one-cycle pulse on the relevant port, so the clearing point is always unambiguous.

// File: rtl/sp_irq_pkg.sv
package sp_irq_pkg;

    localparam int CFG_W = 6;

    // Packed with tx_en as bit 0 up to rx_exc_en as bit 5.
    typedef struct packed {
        logic rx_exc_en;
        logic tx_exc_en;
        logic rxl_en;
        logic txl_en;
        logic rx_en;
        logic tx_en;
    } irq_cfg_t;

    typedef struct packed {
        logic data_flag;
        logic err_flag;
    } dir_stat_t;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DATA = 2'd1,
        REQ_EXC  = 2'd2
    } req_kind_t;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int N_DIR  = 2;

    // Exception outranks the ordinary data request.
    function automatic req_kind_t pick_req(logic data_en, logic data_flag,
                                           logic exc_en, logic exc_flag);
        if (exc_en && exc_flag)
            return REQ_EXC;
        else if (data_en && data_flag)
            return REQ_DATA;
        else
            return REQ_NONE;
    endfunction

endpackage

// File: rtl/sp_irq_cfg.sv
module sp_irq_cfg
    import sp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output irq_cfg_t         cfg
);

    irq_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst || sw_rst)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= irq_cfg_t'(cfg_wdata);
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/sp_irq_dir.sv
module sp_irq_dir
    import sp_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      data_set,
    input  logic      data_clr,
    input  logic      err_set,
    input  logic      stat_rd,
    output dir_stat_t stat
);

    logic data_q, err_q, armed_q;
    logic data_d, err_d, armed_d;

    always_comb begin
        data_d = data_q;
        if (data_set)
            data_d = 1'b1;
        else if (data_clr)
            data_d = 1'b0;

        err_d = err_q;
        if (err_set)
            err_d = 1'b1;
        else if (armed_q && data_clr)
            err_d = 1'b0;

        armed_d = armed_q;
        if (!err_d)
            armed_d = 1'b0;
        else if (stat_rd && err_q)
            armed_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= 1'b0;
            err_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            data_q  <= data_d;
            err_q   <= err_d;
            armed_q <= armed_d;
        end
    end

    assign stat.data_flag = data_q;
    assign stat.err_flag  = err_q;

endmodule

// File: rtl/sp_irq_arb.sv
module sp_irq_arb
    import sp_irq_pkg::*;
(
    input  logic      data_en,
    input  logic      exc_en,
    input  dir_stat_t stat,
    output logic      req_data,
    output logic      req_exc
);

    req_kind_t kind;

    always_comb begin
        kind     = pick_req(data_en, stat.data_flag, exc_en, stat.err_flag);
        req_data = (kind == REQ_DATA);
        req_exc  = (kind == REQ_EXC);
    end

endmodule

// File: rtl/sp_irq_slot.sv
module sp_irq_slot #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] frame_div,
    input  logic             txl_en,
    input  logic             rxl_en,
    input  logic             last_slot_start,
    input  logic             last_slot_end,
    output logic             irq_tx_last,
    output logic             irq_rx_last
);

    logic network;
    assign network = |frame_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_tx_last <= 1'b0;
            irq_rx_last <= 1'b0;
        end else begin
            irq_tx_last <= network && txl_en && last_slot_start;
            irq_rx_last <= network && rxl_en && last_slot_end;
        end
    end

endmodule

// File: rtl/sp_irq_ctrl.sv
module sp_irq_ctrl
    import sp_irq_pkg::*;
#(
    parameter int N_TX  = 2,
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [DIV_W-1:0] frame_div,
    input  logic [N_TX-1:0]  tx_wr,
    input  logic [N_TX-1:0]  tx_chan_en,
    input  logic             tx_dummy_wr,
    input  logic             tx_empty_set,
    input  logic             tx_underrun_evt,
    input  logic             rx_full_set,
    input  logic             rx_read,
    input  logic             rx_overrun_evt,
    input  logic             stat_read,
    input  logic             last_slot_start,
    input  logic             last_slot_end,
    output logic             irq_tx,
    output logic             irq_tx_exc,
    output logic             irq_rx,
    output logic             irq_rx_exc,
    output logic             irq_tx_last,
    output logic             irq_rx_last,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             tx_underrun,
    output logic             rx_overrun
);

    irq_cfg_t cfg;

    sp_irq_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .sw_rst    (sw_rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    // A transmit access counts only for channels that are switched on.
    logic [N_TX-1:0] tx_hit;
    genvar gc;
    generate
        for (gc = 0; gc < N_TX; gc++) begin : g_txch
            assign tx_hit[gc] = tx_wr[gc] && tx_chan_en[gc];
        end
    endgenerate

    logic tx_access;
    assign tx_access = (|tx_hit) || tx_dummy_wr;

    logic      [N_DIR-1:0] d_set, d_clr, e_set, d_en, x_en, r_data, r_exc;
    dir_stat_t             stat [N_DIR];

    assign d_set[DIR_TX] = tx_empty_set;
    assign d_clr[DIR_TX] = tx_access;
    assign e_set[DIR_TX] = tx_underrun_evt;
    assign d_en [DIR_TX] = cfg.tx_en;
    assign x_en [DIR_TX] = cfg.tx_exc_en;

    assign d_set[DIR_RX] = rx_full_set;
    assign d_clr[DIR_RX] = rx_read;
    assign e_set[DIR_RX] = rx_overrun_evt;
    assign d_en [DIR_RX] = cfg.rx_en;
    assign x_en [DIR_RX] = cfg.rx_exc_en;

    genvar gd;
    generate
        for (gd = 0; gd < N_DIR; gd++) begin : g_dir
            sp_irq_dir u_flags (
                .clk      (clk),
                .rst      (rst),
                .data_set (d_set[gd]),
                .data_clr (d_clr[gd]),
                .err_set  (e_set[gd]),
                .stat_rd  (stat_read),
                .stat     (stat[gd])
            );

            sp_irq_arb u_arb (
                .data_en  (d_en[gd]),
                .exc_en   (x_en[gd]),
                .stat     (stat[gd]),
                .req_data (r_data[gd]),
                .req_exc  (r_exc[gd])
            );
        end
    endgenerate

    sp_irq_slot #(.DIV_W(DIV_W)) u_slot (
        .clk             (clk),
        .rst             (rst),
        .frame_div       (frame_div),
        .txl_en          (cfg.txl_en),
        .rxl_en          (cfg.rxl_en),
        .last_slot_start (last_slot_start),
        .last_slot_end   (last_slot_end),
        .irq_tx_last     (irq_tx_last),
        .irq_rx_last     (irq_rx_last)
    );

    assign irq_tx      = r_data[DIR_TX];
    assign irq_tx_exc  = r_exc[DIR_TX];
    assign irq_rx      = r_data[DIR_RX];
    assign irq_rx_exc  = r_exc[DIR_RX];
    assign tx_empty    = stat[DIR_TX].data_flag;
    assign tx_underrun = stat[DIR_TX].err_flag;
    assign rx_full     = stat[DIR_RX].data_flag;
    assign rx_overrun  = stat[DIR_RX].err_flag;

endmodule

// File: rtl/sp_irq_chk.sv
module sp_irq_chk
    import sp_irq_pkg::*;
#(
    parameter int N_TX  = 2,
    parameter int DIV_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             sw_rst,
    input logic [N_TX-1:0]  tx_wr,
    input logic [N_TX-1:0]  tx_chan_en,
    input logic             tx_dummy_wr,
    input logic             tx_empty_set,
    input logic             rx_read,
    input logic             rx_full_set,
    input logic             last_slot_start,
    input logic             last_slot_end,
    input logic [DIV_W-1:0] frame_div,
    input logic             irq_tx,
    input logic             irq_tx_exc,
    input logic             irq_rx,
    input logic             irq_rx_exc,
    input logic             irq_tx_last,
    input logic             irq_rx_last,
    input logic             tx_empty,
    input logic             rx_full,
    input logic             tx_underrun
);

    p_tx_level_r2: assert property (@(posedge clk) disable iff (rst)
        irq_tx |-> tx_empty);

    p_tde_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_dummy_wr && !tx_empty_set) |=> !tx_empty);

    p_rx_level_r4: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> rx_full);

    p_rdf_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_read && !rx_full_set) |=> !rx_full);

    p_tx_single_r5: assert property (@(posedge clk) disable iff (rst)
        !(irq_tx && irq_tx_exc));

    p_rx_single_r6: assert property (@(posedge clk) disable iff (rst)
        !(irq_rx && irq_rx_exc));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_underrun) |-> ($past(|(tx_wr & tx_chan_en)) || $past(tx_dummy_wr)));

    p_txlast_src_r8: assert property (@(posedge clk) disable iff (rst)
        irq_tx_last |-> $past(last_slot_start));

    p_rxlast_src_r9: assert property (@(posedge clk) disable iff (rst)
        irq_rx_last |-> $past(last_slot_end));

    p_ondemand_r10: assert property (@(posedge clk) disable iff (rst)
        (frame_div == '0 && $stable(frame_div)) |=> (!irq_tx_last && !irq_rx_last));

    p_swrst_r11: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (!irq_tx && !irq_tx_exc && !irq_rx && !irq_rx_exc));

endmodule

bind sp_irq_ctrl sp_irq_chk #(.N_TX(N_TX), .DIV_W(DIV_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .sw_rst          (sw_rst),
    .tx_wr           (tx_wr),
    .tx_chan_en      (tx_chan_en),
    .tx_dummy_wr     (tx_dummy_wr),
    .tx_empty_set    (tx_empty_set),
    .rx_read         (rx_read),
    .rx_full_set     (rx_full_set),
    .last_slot_start (last_slot_start),
    .last_slot_end   (last_slot_end),
    .frame_div       (frame_div),
    .irq_tx          (irq_tx),
    .irq_tx_exc      (irq_tx_exc),
    .irq_rx          (irq_rx),
    .irq_rx_exc      (irq_rx_exc),
    .irq_tx_last     (irq_tx_last),
    .irq_rx_last     (irq_rx_last),
    .tx_empty        (tx_empty),
    .rx_full         (rx_full),
    .tx_underrun     (tx_underrun)
);

// File: tb/sp_irq_ctrl_bench.sv
module sp_irq_ctrl_bench;

    localparam int N_TX  = 2;
    localparam int DIV_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sw_rst = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [5:0]       cfg_wdata = '0;
    logic [DIV_W-1:0] frame_div = '0;
    logic [N_TX-1:0]  tx_wr = '0;
    logic [N_TX-1:0]  tx_chan_en = '0;
    logic             tx_dummy_wr = 1'b0;
    logic             tx_empty_set = 1'b0;
    logic             tx_underrun_evt = 1'b0;
    logic             rx_full_set = 1'b0;
    logic             rx_read = 1'b0;
    logic             rx_overrun_evt = 1'b0;
    logic             stat_read = 1'b0;
    logic             last_slot_start = 1'b0;
    logic             last_slot_end = 1'b0;
    logic irq_tx, irq_tx_exc, irq_rx, irq_rx_exc, irq_tx_last, irq_rx_last;
    logic tx_empty, rx_full, tx_underrun, rx_overrun;

    always #2 clk = ~clk;

    sp_irq_ctrl #(.N_TX(N_TX), .DIV_W(DIV_W)) u_sp_irq_ctrl (.*);

    // Observation order: irq_tx, irq_tx_exc, irq_rx, irq_rx_exc,
    // irq_tx_last, irq_rx_last, tx_empty, rx_full, tx_underrun, rx_overrun
    logic [9:0] obs;
    assign obs = {irq_tx, irq_tx_exc, irq_rx, irq_rx_exc, irq_tx_last,
                  irq_rx_last, tx_empty, rx_full, tx_underrun, rx_overrun};

    typedef struct {
        string      req;
        logic [9:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Monitor: pops expected items as the driver posts them, compares at once.
    initial begin
        forever begin
            item_t it;
            wait (q.size() != 0);
            it = q.pop_front();
            checks++;
            if (obs !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%b expected=%b", it.req, obs, it.exp);
            end
        end
    end

    task automatic idle_inputs();
        sw_rst = 0; cfg_wr = 0; tx_wr = '0; tx_dummy_wr = 0; tx_empty_set = 0;
        tx_underrun_evt = 0; rx_full_set = 0; rx_read = 0; rx_overrun_evt = 0;
        stat_read = 0; last_slot_start = 0; last_slot_end = 0;
    endtask

    // Driver: one clock with the inputs already set, then post the expected
    // outputs of the cycle that follows the edge.
    task automatic tick(string req, logic [9:0] exp);
        item_t it;
        @(posedge clk);
        #1;
        it.req = req;
        it.exp = exp;
        q.push_back(it);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic cfg(logic [5:0] v);
        cfg_wr = 1; cfg_wdata = v;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        tx_chan_en = 2'b01;
        repeat (2) @(negedge clk);
        tick("R1 hw reset state", 10'b0000000000);
        rst = 0;
        @(negedge clk);

        // R2: flag without enable gives no request
        tx_empty_set = 1; tick("R2 no enable", 10'b0000001000);
        cfg(6'b000001);   tick("R1 R2 tx enabled", 10'b1000001000);
        // R3: disabled channel write ignored, enabled channel clears
        tx_wr = 2'b10;    tick("R3 disabled channel", 10'b1000001000);
        tx_wr = 2'b01;    tick("R3 enabled channel", 10'b0000000000);
        tx_empty_set = 1; tick("R2 set again", 10'b1000001000);
        tx_dummy_wr = 1;  tick("R3 dummy write", 10'b0000000000);

        // R4 receive path
        rx_full_set = 1;  tick("R4 no enable", 10'b0000000100);
        cfg(6'b000011);   tick("R4 rx enabled", 10'b1010000100 & 10'b0010000100);
        rx_read = 1;      tick("R4 read clears", 10'b0000000000);

        // R12 set beats clear
        tx_empty_set = 1; tx_dummy_wr = 1; tick("R12 tx set wins", 10'b1000001000);
        rx_full_set = 1; rx_read = 1;      tick("R12 rx set wins", 10'b1010001100);
        rx_read = 1; tx_dummy_wr = 1;      tick("R3 R4 clear both", 10'b0000000000);

        // R5 / R7 transmit exception
        tx_empty_set = 1;    tick("R2 before exc", 10'b1000001000);
        tx_underrun_evt = 1; tick("R7 underrun without exc enable", 10'b1000001010);
        cfg(6'b010011);      tick("R5 exc replaces data", 10'b0100001010);
        tx_dummy_wr = 1;     tick("R7 access without status read", 10'b0100000010);
        stat_read = 1;       tick("R7 status read alone", 10'b0100000010);
        tx_dummy_wr = 1;     tick("R7 status then access", 10'b0000000000);

        // R6 / R7 receive exception
        cfg(6'b110011);      tick("R1 all data enables", 10'b0000000000);
        rx_full_set = 1;     tick("R4 before exc", 10'b0010000100);
        rx_overrun_evt = 1;  tick("R6 exc replaces data", 10'b0001000101);
        rx_read = 1;         tick("R7 read without status", 10'b0001000001);
        stat_read = 1;       tick("R7 rx status read", 10'b0001000001);
        rx_read = 1;         tick("R7 rx cleared", 10'b0000000000);

        // R8 / R9 last-slot pulses in network mode
        cfg(6'b001100); frame_div = 5'd3; tick("R1 last-slot enables", 10'b0000000000);
        last_slot_start = 1; tick("R8 tx last pulse", 10'b0000100000);
        tick("R8 pulse one cycle", 10'b0000000000);
        last_slot_end = 1;   tick("R9 rx last pulse", 10'b0000010000);
        tick("R9 pulse one cycle", 10'b0000000000);

        // R10 on-demand mode
        frame_div = 5'd0;    tick("R10 idle", 10'b0000000000);
        last_slot_start = 1; tick("R10 tx inhibited", 10'b0000000000);
        tick("R10 gap", 10'b0000000000);
        last_slot_end = 1;   tick("R10 rx inhibited", 10'b0000000000);

        // R11 resets
        cfg(6'b000001); tx_empty_set = 1; tick("R11 setup", 10'b1000001000);
        sw_rst = 1;                       tick("R11 sw reset keeps flag", 10'b0000001000);
        sw_rst = 1; cfg(6'b000001);       tick("R11 sw reset beats write", 10'b0000001000);
        cfg(6'b000001);                   tick("R11 re-enable", 10'b1000001000);
        rst = 1;                          tick("R11 hw reset clears all", 10'b0000000000);
        rst = 0;
        tx_empty_set = 1;                 tick("R11 enables stay cleared", 10'b0000001000);

        #1;
        done = 1'b1;
        report();
        $finish;
    end

endmodule